// File: doc/BRIEF.md
# Stream Identifier Span Filter Matcher

This block sits beside a bank of event counters and decides, for every incoming transaction tagged with a 32-bit stream identifier, which counters are allowed to count it. Each counter has its own programmed match value and a span flag. With the span flag clear, the identifier must match the value exactly. With the span flag set, the value also says how many low bits to ignore. The lowest zero bit of the value and every bit below it become "don't care", and all bits above are compared.

A global mode makes counter 0's match value and span flag govern every counter, and the settings of the other counters are then disregarded. The identifier arrives with a valid strobe. The block answers with one accept bit per counter, held in a register, together with a registered valid flag one clock later. Decoding of the programming registers and the counters themselves live elsewhere.

Top module: `sidf_matcher`

## Requirements
- R1: With the span flag clear, a counter accepts the identifier only when all 32 bits equal its match value. A difference in any single bit rejects it, and an all-ones value then matches only 0xFFFFFFFF.
- R2: With the span flag set, let position p be the lowest zero bit of the match value (bit 0 is the least significant bit). Bits p down to 0 of the identifier are ignored, and bits above p must equal the match value.
- R3: Match value 0x42 with the span flag set accepts identifiers 0x42 and 0x43 and rejects 0x40, 0x41 and 0x44.
- R4: A match value of all ones with the span flag set accepts every identifier.
- R5: While the global mode input is high, every counter's accept bit uses counter 0's match value and span flag, so all accept bits are equal. The other counters' settings have no effect.
- R6: While the global mode input is low, each counter's accept bit depends only on its own match value and span flag.
- R7: Accept bits and the accept valid flag appear exactly one clock after the cycle in which the identifier valid strobe is high. In a cycle that follows one without the strobe, the valid flag and every accept bit are 0.
- R8: A synchronous active-high reset clears every accept bit and the accept valid flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sid_valid_i | input | 1 | Identifier valid strobe |
| sid_i | input | 32 | Stream identifier of the transaction |
| global_mode_i | input | 1 | 1: counter 0's filter applies to all counters |
| match_val_i | input | NUM_CTR*32 | Match values, counter n in bits [32n+31:32n] |
| span_i | input | NUM_CTR | Span flag per counter, bit n for counter n |
| accept_o | output | NUM_CTR | Registered accept bit per counter |
| accept_valid_o | output | 1 | Registered copy of the valid strobe |

## Verification
The hardest situation to reach is a global-mode decision that differs from what the per-counter settings would give. It only shows up when the other counters hold settings that would accept an identifier that counter 0 rejects, or reject one that counter 0 accepts. The stimulus therefore gives each counter a deliberately different filter, applies the same identifiers with the mode both high and low, and compares the accept pattern. Span widths are covered from one ignored bit up to all 32 bits. For each width, identifiers sit just inside and just outside the ignored field.

// File: rtl/sidf_pkg.sv
package sidf_pkg;

    localparam int SID_W = 32;

    typedef struct packed {
        logic [SID_W-1:0] value;  // compare value, ignored bits zeroed
        logic [SID_W-1:0] care;   // 1 = bit must match
    } sidf_filter_t;

    // Bits at and below the lowest zero of the match value.
    // Adding one flips exactly that run, so the xor exposes it.
    // An all-ones value wraps to zero and yields all ones.
    function automatic logic [SID_W-1:0] span_ignore_bits(input logic [SID_W-1:0] mval);
        logic [SID_W-1:0] inc;
        inc = mval + {{(SID_W-1){1'b0}}, 1'b1};
        return mval ^ inc;
    endfunction

    function automatic sidf_filter_t build_filter(input logic [SID_W-1:0] mval,
                                                  input logic            span);
        sidf_filter_t f;
        f.care  = span ? ~span_ignore_bits(mval) : {SID_W{1'b1}};
        f.value = mval & f.care;
        return f;
    endfunction

endpackage

// File: rtl/sidf_src_select.sv
module sidf_src_select
    import sidf_pkg::*;
#(
    parameter int NUM_CTR = 4
) (
    input  logic                            global_mode_i,
    input  logic [NUM_CTR-1:0][SID_W-1:0]   own_val_i,
    input  logic [NUM_CTR-1:0]              own_span_i,
    output logic [NUM_CTR-1:0][SID_W-1:0]   eff_val_o,
    output logic [NUM_CTR-1:0]              eff_span_o
);

    genvar g;
    generate
        for (g = 0; g < NUM_CTR; g++) begin : g_lane_src
            if (g == 0) begin : g_base
                assign eff_val_o[g]  = own_val_i[0];
                assign eff_span_o[g] = own_span_i[0];
            end else begin : g_other
                assign eff_val_o[g]  = global_mode_i ? own_val_i[0]  : own_val_i[g];
                assign eff_span_o[g] = global_mode_i ? own_span_i[0] : own_span_i[g];
            end
        end
    endgenerate

endmodule

// File: rtl/sidf_lane.sv
module sidf_lane
    import sidf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sid_valid_i,
    input  logic [SID_W-1:0] sid_i,
    input  logic [SID_W-1:0] mval_i,
    input  logic             span_i,
    output logic             accept_o
);

    sidf_filter_t filt;
    logic         hit;

    always_comb begin
        filt = build_filter(mval_i, span_i);
        hit  = ((sid_i & filt.care) == filt.value);
    end

    always_ff @(posedge clk) begin
        if (rst)
            accept_o <= 1'b0;
        else
            accept_o <= sid_valid_i & hit;
    end

    p_exact_hit_r1: assert property (@(posedge clk) disable iff (rst)
        (sid_valid_i && !span_i && sid_i == mval_i) |=> accept_o);

    p_exact_miss_r1: assert property (@(posedge clk) disable iff (rst)
        (sid_valid_i && !span_i && sid_i != mval_i) |=> !accept_o);

    p_all_wild_r4: assert property (@(posedge clk) disable iff (rst)
        (sid_valid_i && span_i && (&mval_i)) |=> accept_o);

    p_idle_low_r7: assert property (@(posedge clk) disable iff (rst)
        !sid_valid_i |=> !accept_o);

endmodule

// File: rtl/sidf_matcher.sv
module sidf_matcher
    import sidf_pkg::*;
#(
    parameter int NUM_CTR = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       sid_valid_i,
    input  logic [31:0]                sid_i,
    input  logic                       global_mode_i,
    input  logic [NUM_CTR*32-1:0]      match_val_i,
    input  logic [NUM_CTR-1:0]         span_i,
    output logic [NUM_CTR-1:0]         accept_o,
    output logic                       accept_valid_o
);

    logic [NUM_CTR-1:0][SID_W-1:0] own_val;
    logic [NUM_CTR-1:0][SID_W-1:0] eff_val;
    logic [NUM_CTR-1:0]            eff_span;

    assign own_val = match_val_i;

    sidf_src_select #(.NUM_CTR(NUM_CTR)) u_select (
        .global_mode_i (global_mode_i),
        .own_val_i     (own_val),
        .own_span_i    (span_i),
        .eff_val_o     (eff_val),
        .eff_span_o    (eff_span)
    );

    genvar g;
    generate
        for (g = 0; g < NUM_CTR; g++) begin : g_lane
            sidf_lane u_lane (
                .clk         (clk),
                .rst         (rst),
                .sid_valid_i (sid_valid_i),
                .sid_i       (sid_i),
                .mval_i      (eff_val[g]),
                .span_i      (eff_span[g]),
                .accept_o    (accept_o[g])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            accept_valid_o <= 1'b0;
        else
            accept_valid_o <= sid_valid_i;
    end

    p_valid_delay_r7: assert property (@(posedge clk) disable iff (rst)
        sid_valid_i |=> accept_valid_o);

    p_valid_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !sid_valid_i |=> (!accept_valid_o && accept_o == '0));

    p_global_uniform_r5: assert property (@(posedge clk) disable iff (rst)
        (global_mode_i && sid_valid_i) |=>
            ($countones(accept_o) == 0 || $countones(accept_o) == NUM_CTR));

endmodule

// File: tb/sidf_matcher_bench.sv
module sidf_matcher_bench;

    localparam int NC = 4;

    logic            clk = 1'b0;
    logic            rst;
    logic            sid_valid_i;
    logic [31:0]     sid_i;
    logic            global_mode_i;
    logic [NC*32-1:0] match_val_i;
    logic [NC-1:0]   span_i;
    logic [NC-1:0]   accept_o;
    logic            accept_valid_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    sidf_matcher #(.NUM_CTR(NC)) u_sidf_matcher (
        .clk            (clk),
        .rst            (rst),
        .sid_valid_i    (sid_valid_i),
        .sid_i          (sid_i),
        .global_mode_i  (global_mode_i),
        .match_val_i    (match_val_i),
        .span_i         (span_i),
        .accept_o       (accept_o),
        .accept_valid_o (accept_valid_o)
    );

    // {span, match value, stream id, expected accept}
    localparam int NV = 21;
    localparam logic [65:0] VEC [NV] = '{
        {1'b0, 32'h12345678, 32'h12345678, 1'b1},  // R1
        {1'b0, 32'h12345678, 32'h12345679, 1'b0},  // R1
        {1'b0, 32'h12345678, 32'h92345678, 1'b0},  // R1
        {1'b0, 32'hFFFFFFFF, 32'hFFFFFFFE, 1'b0},  // R1
        {1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1},  // R1
        {1'b1, 32'h00000042, 32'h00000042, 1'b1},  // R3
        {1'b1, 32'h00000042, 32'h00000043, 1'b1},  // R3
        {1'b1, 32'h00000042, 32'h00000040, 1'b0},  // R3
        {1'b1, 32'h00000042, 32'h00000041, 1'b0},  // R3
        {1'b1, 32'h00000042, 32'h00000044, 1'b0},  // R3
        {1'b1, 32'h000000A7, 32'h000000A0, 1'b1},  // R2 low 4 ignored
        {1'b1, 32'h000000A7, 32'h000000AF, 1'b1},  // R2
        {1'b1, 32'h000000A7, 32'h000000B0, 1'b0},  // R2
        {1'b1, 32'h0000FFFF, 32'h0001ABCD, 1'b1},  // R2 low 17 ignored
        {1'b1, 32'h0000FFFF, 32'h00020000, 1'b0},  // R2
        {1'b1, 32'h7FFFFFFF, 32'h80000000, 1'b1},  // R2 all 32 ignored
        {1'b1, 32'hFFFFFFFF, 32'h00000000, 1'b1},  // R4
        {1'b1, 32'hFFFFFFFF, 32'hDEADBEEF, 1'b1},  // R4
        {1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1},  // R4
        {1'b0, 32'h00000042, 32'h00000043, 1'b0},  // R1 span off
        {1'b1, 32'h12345678, 32'h12345679, 1'b1}   // R2 bit 0 ignored
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    // Strobe one identifier, sample the registered answer one clock later.
    task automatic strobe(input logic [31:0] sid, output logic [NC-1:0] acc, output logic vld);
        @(negedge clk);
        sid_i       = sid;
        sid_valid_i = 1'b1;
        @(negedge clk);
        acc = accept_o;
        vld = accept_valid_o;
        sid_valid_i = 1'b0;
        sid_i       = 32'h0;
    endtask

    task automatic program_lane(input int n, input logic [31:0] v, input logic s);
        match_val_i[n*32 +: 32] = v;
        span_i[n]               = s;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [NC-1:0] acc;
        logic          vld;
        rst           = 1'b1;
        sid_valid_i   = 1'b0;
        sid_i         = 32'h0;
        global_mode_i = 1'b0;
        match_val_i   = '0;
        span_i        = '0;
        repeat (3) @(negedge clk);
        check("R8 reset accept", {28'h0, accept_o}, 32'h0);
        check("R8 reset valid", {31'h0, accept_valid_o}, 32'h0);
        rst = 1'b0;

        // Table: every lane carries the same filter.
        for (int i = 0; i < NV; i++) begin
            for (int n = 0; n < NC; n++)
                program_lane(n, VEC[i][64:33], VEC[i][65]);
            strobe(VEC[i][32:1], acc, vld);
            check($sformatf("R1/R2/R3/R4 vector %0d", i), {28'h0, acc},
                  VEC[i][0] ? 32'hF : 32'h0);
            check("R7 valid one clock after strobe", {31'h0, vld}, 32'h1);
        end

        // R7: the cycle after a strobe-free cycle shows nothing.
        @(negedge clk);
        check("R7 idle accept", {28'h0, accept_o}, 32'h0);
        check("R7 idle valid", {31'h0, accept_valid_o}, 32'h0);

        // Distinct filters per lane.
        program_lane(0, 32'h00000042, 1'b1);
        program_lane(1, 32'h00000099, 1'b0);
        program_lane(2, 32'hFFFFFFFF, 1'b1);
        program_lane(3, 32'h00000043, 1'b0);

        global_mode_i = 1'b0;
        strobe(32'h43, acc, vld);
        check("R6 own filters sid 0x43", {28'h0, acc}, 32'hD);
        strobe(32'h99, acc, vld);
        check("R6 own filters sid 0x99", {28'h0, acc}, 32'h6);

        global_mode_i = 1'b1;
        strobe(32'h43, acc, vld);
        check("R5 global sid 0x43", {28'h0, acc}, 32'hF);
        strobe(32'h99, acc, vld);
        check("R5 global sid 0x99", {28'h0, acc}, 32'h0);
        strobe(32'h12345, acc, vld);
        check("R5 global sid 0x12345", {28'h0, acc}, 32'h0);
        global_mode_i = 1'b0;

        // R8: reset during a strobe clears the answer.
        @(negedge clk);
        sid_i       = 32'h43;
        sid_valid_i = 1'b1;
        rst         = 1'b1;
        @(negedge clk);
        check("R8 reset overrides strobe accept", {28'h0, accept_o}, 32'h0);
        check("R8 reset overrides strobe valid", {31'h0, accept_valid_o}, 32'h0);
        rst         = 1'b0;
        sid_valid_i = 1'b0;
        strobe(32'h43, acc, vld);
        check("R7 after reset accept", {28'h0, acc}, 32'hD);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule